// File: doc/BRIEF.md
# Windowed SRAM with Configurable Core Routing

This block wraps a small on-chip SRAM and decides how accesses from a processor core reach it. A configuration register holds a base address and four control flags. The core can write the register but cannot read it. A debug port can read and write it. Every core request whose address falls in a fixed 256 MB window hits the array. Only the low offset bits select a word, so addresses that differ only in the bits above the array size reach the same location.

When the register is marked valid, core hits complete in the cycle in which they are presented. After reset the register is not valid and the side-door path is enabled. In that state core hits still complete, but they go through a fixed-latency engine that is shared with a separate side-door port (a system-bus master). A priority flag decides which request the block takes when the core and the side-door port ask in the same cycle. A write-protect flag can block writes from the side-door port.

Top module: `sram_window_ctrl`

## Requirements
- R1: Reset sets the flag field to bit0 valid=0, bit1 priority=0, bit2 side-door write-protect=0 and bit3 side-door enable=1. Reset does not change the base field in bits [31:15].
- R2: A core register write (`cfg_core_we`) and a debug write (`dbg_we`) both update the register at the next clock edge. The debug read port `dbg_rdata` always shows the register. If both writes happen in the same cycle, the debug value is kept.
- R3: Bits [14:4] of the register are reserved. Writes do not store them, and `dbg_rdata` returns them as zero.
- R4: A core request hits only when address bits [31:28] equal 0x8. A core request outside that window gets no `core_ready` and does not change the array.
- R5: Address bits [11:2] select one of 1024 words. Two core addresses that differ only in bits [27:12] reach the same word.
- R6: With valid=1, a core hit asserts `core_ready` in the first cycle of its request, provided the engine is idle and the core wins arbitration.
- R7: With valid=0 and side-door enable=1, a core hit goes through the engine. It asserts `core_ready` in the third cycle of its request, with no error.
- R8: A side-door request asserts `bd_ready` in the third cycle of its request when it is not delayed by arbitration. It selects the word with `bd_addr[11:2]`.
- R9: Byte-enable bit i writes data bits [8i+7:8i]. The other bytes of the word are left unchanged.
- R10: With write-protect=1, a side-door write leaves the array unchanged. It still completes, and `bd_err` is high in its `bd_ready` cycle. Side-door reads are not affected.
- R11: With valid=0 and side-door enable=0, a core hit asserts `core_ready` and `core_err` in its first cycle and leaves the array unchanged.
- R12: With side-door enable=0, a side-door access completes with `bd_err` high and `bd_rdata` equal to zero. It does not change the array.
- R13: When the core hits and the side-door port requests in the same idle cycle, the core is served first if priority=1 and the side-door port is served first if priority=0. The other request waits, and `core_ready` and `bd_ready` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_core_we | input | 1 | Core write strobe for the register |
| cfg_core_wdata | input | 32 | Core write data for the register |
| dbg_we | input | 1 | Debug write strobe for the register |
| dbg_wdata | input | 32 | Debug write data for the register |
| dbg_rdata | output | 32 | Register value for debug reads |
| core_req | input | 1 | Core request, held until ready |
| core_addr | input | 32 | Core byte address |
| core_we | input | 1 | Core write (1) or read (0) |
| core_be | input | 4 | Core byte enables |
| core_wdata | input | 32 | Core write data |
| core_rdata | output | 32 | Core read data, valid with ready |
| core_ready | output | 1 | Core access complete |
| core_err | output | 1 | Core error response |
| bd_req | input | 1 | Side-door request, held until ready |
| bd_addr | input | 32 | Side-door byte address |
| bd_we | input | 1 | Side-door write (1) or read (0) |
| bd_be | input | 4 | Side-door byte enables |
| bd_wdata | input | 32 | Side-door write data |
| bd_rdata | output | 32 | Side-door read data, valid with ready |
| bd_ready | output | 1 | Side-door access complete |
| bd_err | output | 1 | Side-door error response |

## Verification
The bench runs core traffic under each flag combination: the slow route straight after reset, the fast route, and the error response. A design that ignored the valid flag would show a latency of one cycle where three are expected. A design that misrouted error cases would corrupt the word that the bench reads back afterwards. Aliasing is checked by reading one word through far-apart window addresses, and by holding a write outside the window for several cycles. A decoder that used too many or too few address bits would return the wrong data or answer the out-of-window request. Same-cycle core and side-door requests are issued under both priority settings, and the latency of each side is counted, so an inverted priority or a double grant shows up as swapped cycle counts. Write-protect and side-door disable are checked by reading the word back after the blocked write.

// File: rtl/sramw_pkg.sv
package sramw_pkg;

    localparam int FLAG_W = 4;

    // Flag field, bit 0 upward: valid, priority, write-protect, side-door enable
    typedef struct packed {
        logic bd_en;
        logic wprot;
        logic prio;
        logic valid;
    } sramw_flags_t;

    localparam sramw_flags_t FLAGS_RST = '{bd_en: 1'b1, wprot: 1'b0, prio: 1'b0, valid: 1'b0};

    typedef enum logic {
        OWN_BD   = 1'b0,
        OWN_CORE = 1'b1
    } sramw_owner_e;

endpackage

// File: rtl/sramw_cfg.sv
module sramw_cfg
    import sramw_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int BASE_LSB = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_we,
    input  logic [DATA_W-1:0] core_wdata,
    input  logic              dbg_we,
    input  logic [DATA_W-1:0] dbg_wdata,
    output sramw_flags_t      flags,
    output logic [DATA_W-1:0] rdata
);
    localparam int BASE_W = DATA_W - BASE_LSB;
    localparam int RSV_W  = BASE_LSB - FLAG_W;

    sramw_flags_t      flags_d, flags_q;
    logic [BASE_W-1:0] base_d, base_q;
    logic [DATA_W-1:0] wr_word;
    logic              unused_rsv;

    always_comb begin
        flags_d = flags_q;
        base_d  = base_q;
        wr_word = dbg_we ? dbg_wdata : core_wdata;
        if (dbg_we || core_we) begin
            flags_d = sramw_flags_t'(wr_word[FLAG_W-1:0]);
            base_d  = wr_word[DATA_W-1:BASE_LSB];
        end
    end

    assign unused_rsv = ^wr_word[BASE_LSB-1:FLAG_W];

    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= FLAGS_RST;
        else        flags_q <= flags_d;
    end

    // Base field survives reset
    always_ff @(posedge clk) begin
        base_q <= base_d;
    end

    assign flags = flags_q;
    assign rdata = {base_q, {RSV_W{1'b0}}, flags_q};

endmodule

// File: rtl/sramw_mem.sv
module sramw_mem #(
    parameter int IDX_W  = 10,
    parameter int DATA_W = 32
) (
    input  logic                clk,
    input  logic                we,
    input  logic [IDX_W-1:0]    idx,
    input  logic [DATA_W/8-1:0] be,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rdata
);
    localparam int LANES = DATA_W / 8;
    localparam int DEPTH = 1 << IDX_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];

        always_ff @(posedge clk) begin
            if (we && be[g]) lane_mem[idx] <= wdata[8*g +: 8];
        end

        assign rdata[8*g +: 8] = lane_mem[idx];
    end

endmodule

// File: rtl/sramw_route.sv
module sramw_route
    import sramw_pkg::*;
#(
    parameter int          ADDR_W  = 32,
    parameter int          DATA_W  = 32,
    parameter int          IDX_W   = 10,
    parameter int          LAT     = 3,
    parameter int          WIN_W   = 4,
    parameter logic [3:0]  WIN_TAG = 4'h8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  sramw_flags_t        flags,
    input  logic                core_req,
    input  logic [ADDR_W-1:0]   core_addr,
    input  logic                core_we,
    input  logic [DATA_W/8-1:0] core_be,
    input  logic [DATA_W-1:0]   core_wdata,
    output logic [DATA_W-1:0]   core_rdata,
    output logic                core_ready,
    output logic                core_err,
    input  logic                bd_req,
    input  logic [ADDR_W-1:0]   bd_addr,
    input  logic                bd_we,
    input  logic [DATA_W/8-1:0] bd_be,
    input  logic [DATA_W-1:0]   bd_wdata,
    output logic [DATA_W-1:0]   bd_rdata,
    output logic                bd_ready,
    output logic                bd_err,
    output logic                mem_we,
    output logic [IDX_W-1:0]    mem_idx,
    output logic [DATA_W/8-1:0] mem_be,
    output logic [DATA_W-1:0]   mem_wdata,
    input  logic [DATA_W-1:0]   mem_rdata
);
    localparam int BE_W     = DATA_W / 8;
    localparam int IDX_LSB  = $clog2(BE_W);
    localparam int IDX_HI   = IDX_LSB + IDX_W - 1;
    localparam int CNT_W    = (LAT > 2) ? $clog2(LAT) : 1;
    localparam int LAST_CNT = LAT - 2;

    typedef struct packed {
        logic              busy;
        sramw_owner_e      owner;
        logic [CNT_W-1:0]  cnt;
        logic [IDX_W-1:0]  idx;
        logic              we;
        logic [BE_W-1:0]   be;
        logic [DATA_W-1:0] wdata;
    } eng_t;

    eng_t eng_d, eng_q;

    logic in_win, core_hit, idle, core_first;
    logic fast_go, err_go, slow_go, bd_go;
    logic eng_last, bd_done, core_slow_done, bd_fault;
    logic unused_addr;

    assign unused_addr = ^{core_addr[IDX_LSB-1:0], core_addr[ADDR_W-WIN_W-1:IDX_HI+1],
                           bd_addr[IDX_LSB-1:0], bd_addr[ADDR_W-1:IDX_HI+1]};

    always_comb begin
        in_win     = (core_addr[ADDR_W-1 -: WIN_W] == WIN_TAG[WIN_W-1:0]);
        core_hit   = core_req && in_win;
        idle       = !eng_q.busy;
        core_first = core_hit && (flags.prio || !bd_req);

        fast_go = idle && core_first && flags.valid;
        err_go  = idle && core_first && !flags.valid && !flags.bd_en;
        slow_go = idle && core_first && !flags.valid && flags.bd_en;
        bd_go   = idle && bd_req && !core_first;

        eng_last       = eng_q.busy && (eng_q.cnt == CNT_W'(LAST_CNT));
        bd_done        = eng_last && (eng_q.owner == OWN_BD);
        core_slow_done = eng_last && (eng_q.owner == OWN_CORE);
        bd_fault       = bd_done && (!flags.bd_en || (eng_q.we && flags.wprot));

        eng_d = eng_q;
        if (eng_q.busy) begin
            if (eng_last) eng_d.busy = 1'b0;
            else          eng_d.cnt  = eng_q.cnt + 1'b1;
        end else if (slow_go || bd_go) begin
            eng_d.busy  = 1'b1;
            eng_d.cnt   = '0;
            eng_d.owner = slow_go ? OWN_CORE : OWN_BD;
            eng_d.idx   = slow_go ? core_addr[IDX_HI:IDX_LSB] : bd_addr[IDX_HI:IDX_LSB];
            eng_d.we    = slow_go ? core_we : bd_we;
            eng_d.be    = slow_go ? core_be : bd_be;
            eng_d.wdata = slow_go ? core_wdata : bd_wdata;
        end

        mem_we    = (fast_go && core_we) || (eng_last && eng_q.we && !bd_fault);
        mem_idx   = fast_go ? core_addr[IDX_HI:IDX_LSB] : eng_q.idx;
        mem_be    = fast_go ? core_be : eng_q.be;
        mem_wdata = fast_go ? core_wdata : eng_q.wdata;

        core_ready = fast_go || err_go || core_slow_done;
        core_err   = err_go;
        core_rdata = (fast_go || core_slow_done) ? mem_rdata : '0;

        bd_ready = bd_done;
        bd_err   = bd_fault;
        bd_rdata = (bd_done && flags.bd_en) ? mem_rdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q       <= '0;
            eng_q.owner <= OWN_BD;
        end else begin
            eng_q <= eng_d;
        end
    end

endmodule

// File: rtl/sram_window_ctrl.sv
module sram_window_ctrl
    import sramw_pkg::*;
#(
    parameter int         ADDR_W   = 32,
    parameter int         DATA_W   = 32,
    parameter int         IDX_W    = 10,
    parameter int         BD_LAT   = 3,
    parameter int         BASE_LSB = 15,
    parameter int         WIN_W    = 4,
    parameter logic [3:0] WIN_TAG  = 4'h8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_core_we,
    input  logic [DATA_W-1:0]   cfg_core_wdata,
    input  logic                dbg_we,
    input  logic [DATA_W-1:0]   dbg_wdata,
    output logic [DATA_W-1:0]   dbg_rdata,
    input  logic                core_req,
    input  logic [ADDR_W-1:0]   core_addr,
    input  logic                core_we,
    input  logic [DATA_W/8-1:0] core_be,
    input  logic [DATA_W-1:0]   core_wdata,
    output logic [DATA_W-1:0]   core_rdata,
    output logic                core_ready,
    output logic                core_err,
    input  logic                bd_req,
    input  logic [ADDR_W-1:0]   bd_addr,
    input  logic                bd_we,
    input  logic [DATA_W/8-1:0] bd_be,
    input  logic [DATA_W-1:0]   bd_wdata,
    output logic [DATA_W-1:0]   bd_rdata,
    output logic                bd_ready,
    output logic                bd_err
);
    localparam int BE_W = DATA_W / 8;

    sramw_flags_t      flags;
    logic              mem_we;
    logic [IDX_W-1:0]  mem_idx;
    logic [BE_W-1:0]   mem_be;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    sramw_cfg #(.DATA_W(DATA_W), .BASE_LSB(BASE_LSB)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .core_we(cfg_core_we), .core_wdata(cfg_core_wdata),
        .dbg_we(dbg_we), .dbg_wdata(dbg_wdata),
        .flags(flags), .rdata(dbg_rdata)
    );

    sramw_route #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
        .LAT(BD_LAT), .WIN_W(WIN_W), .WIN_TAG(WIN_TAG)
    ) u_route (
        .clk(clk), .rst_n(rst_n), .flags(flags),
        .core_req(core_req), .core_addr(core_addr), .core_we(core_we),
        .core_be(core_be), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .core_ready(core_ready), .core_err(core_err),
        .bd_req(bd_req), .bd_addr(bd_addr), .bd_we(bd_we),
        .bd_be(bd_be), .bd_wdata(bd_wdata), .bd_rdata(bd_rdata),
        .bd_ready(bd_ready), .bd_err(bd_err),
        .mem_we(mem_we), .mem_idx(mem_idx), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    sramw_mem #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_mem (
        .clk(clk), .we(mem_we), .idx(mem_idx), .be(mem_be),
        .wdata(mem_wdata), .rdata(mem_rdata)
    );

endmodule

// File: rtl/sramw_checks.sv
module sramw_checks #(
    parameter int         BASE_LSB = 15,
    parameter int         WIN_W    = 4,
    parameter logic [3:0] WIN_TAG  = 4'h8,
    parameter int         BD_LAT   = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic [BASE_LSB-1:0] cfg_low,
    input logic                core_req,
    input logic [WIN_W-1:0]    core_win,
    input logic                core_ready,
    input logic                core_err,
    input logic                bd_req,
    input logic                bd_we,
    input logic                bd_ready,
    input logic                bd_err
);
    logic [7:0] bd_run_q;

    // Cycles the current side-door request has waited so far
    always_ff @(posedge clk) begin
        if (!rst_n || !bd_req || bd_ready) bd_run_q <= '0;
        else if (bd_run_q != 8'hFF)         bd_run_q <= bd_run_q + 8'd1;
    end

    a_r1_reset_flags: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_low[3:0] == 4'b1000));

    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_low[BASE_LSB-1:4] == '0);

    a_r4_miss_no_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (core_win != WIN_TAG[WIN_W-1:0]) |-> !core_ready);

    a_r4_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        core_ready |-> core_req);

    a_r8_bd_latency: assert property (@(posedge clk) disable iff (!rst_n)
        bd_ready |-> (bd_req && (int'(bd_run_q) >= BD_LAT - 1)));

    a_r10_wprot_err: assert property (@(posedge clk) disable iff (!rst_n)
        (bd_ready && bd_we && cfg_low[2]) |-> bd_err);

    a_r11_err_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        core_err |-> core_ready);

    a_r12_bden_err: assert property (@(posedge clk) disable iff (!rst_n)
        (bd_ready && !cfg_low[3]) |-> bd_err);

    a_r12_err_with_ready: assert property (@(posedge clk) disable iff (!rst_n)
        bd_err |-> bd_ready);

    a_r13_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_ready && bd_ready));

endmodule

bind sram_window_ctrl sramw_checks #(
    .BASE_LSB(BASE_LSB), .WIN_W(WIN_W), .WIN_TAG(WIN_TAG), .BD_LAT(BD_LAT)
) u_checks (
    .clk(clk), .rst_n(rst_n),
    .cfg_low(dbg_rdata[BASE_LSB-1:0]),
    .core_req(core_req), .core_win(core_addr[ADDR_W-1 -: WIN_W]),
    .core_ready(core_ready), .core_err(core_err),
    .bd_req(bd_req), .bd_we(bd_we), .bd_ready(bd_ready), .bd_err(bd_err)
);

// File: tb/test_sram_window_ctrl.sv
`timescale 1ns/1ps
module test_sram_window_ctrl;

    localparam real CLK_PERIOD = 8.0;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_core_we;
    logic [31:0] cfg_core_wdata;
    logic        dbg_we;
    logic [31:0] dbg_wdata;
    logic [31:0] dbg_rdata;
    logic        core_req, core_we;
    logic [31:0] core_addr, core_wdata, core_rdata;
    logic [3:0]  core_be;
    logic        core_ready, core_err;
    logic        bd_req, bd_we;
    logic [31:0] bd_addr, bd_wdata, bd_rdata;
    logic [3:0]  bd_be;
    logic        bd_ready, bd_err;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sram_window_ctrl i_sram_window_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cfg_core_we(cfg_core_we), .cfg_core_wdata(cfg_core_wdata),
        .dbg_we(dbg_we), .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata),
        .core_req(core_req), .core_addr(core_addr), .core_we(core_we),
        .core_be(core_be), .core_wdata(core_wdata), .core_rdata(core_rdata),
        .core_ready(core_ready), .core_err(core_err),
        .bd_req(bd_req), .bd_addr(bd_addr), .bd_we(bd_we),
        .bd_be(bd_be), .bd_wdata(bd_wdata), .bd_rdata(bd_rdata),
        .bd_ready(bd_ready), .bd_err(bd_err)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic dbg_write(input logic [31:0] d);
        dbg_we = 1'b1; dbg_wdata = d;
        @(negedge clk);
        dbg_we = 1'b0;
        #1;
    endtask

    task automatic core_cfg(input logic [31:0] d);
        cfg_core_we = 1'b1; cfg_core_wdata = d;
        @(negedge clk);
        cfg_core_we = 1'b0;
        #1;
    endtask

    // Called at a negedge; returns at a negedge
    task automatic core_access(input logic [31:0] a, input logic w, input logic [3:0] be,
                               input logic [31:0] d, output logic [31:0] rd,
                               output logic er, output int cyc);
        bit done = 0;
        core_req = 1'b1; core_addr = a; core_we = w; core_be = be; core_wdata = d;
        cyc = 0; rd = '0; er = 1'b0;
        while (!done) begin
            #1;
            cyc++;
            if (core_ready) begin done = 1; rd = core_rdata; er = core_err; end
            @(negedge clk);
            if (cyc > 40) done = 1;
        end
        core_req = 1'b0;
    endtask

    task automatic bd_access(input logic [31:0] a, input logic w, input logic [3:0] be,
                             input logic [31:0] d, output logic [31:0] rd,
                             output logic er, output int cyc);
        bit done = 0;
        bd_req = 1'b1; bd_addr = a; bd_we = w; bd_be = be; bd_wdata = d;
        cyc = 0; rd = '0; er = 1'b0;
        while (!done) begin
            #1;
            cyc++;
            if (bd_ready) begin done = 1; rd = bd_rdata; er = bd_err; end
            @(negedge clk);
            if (cyc > 40) done = 1;
        end
        bd_req = 1'b0;
    endtask

    task automatic t_reset();
        #1;
        check("R1 reset flags", {17'd0, dbg_rdata[14:0]}, 32'h0000_0008);
    endtask

    task automatic t_reserved();
        dbg_write(32'hFFFF_FFFF);
        check("R3 reserved bits read zero", dbg_rdata, 32'hFFFF_800F);
    endtask

    task automatic t_cfg_ports();
        core_cfg(32'h8000_0008);
        check("R2 core write visible to debug", dbg_rdata, 32'h8000_0008);
        cfg_core_we = 1'b1; cfg_core_wdata = 32'h8000_0001;
        dbg_we = 1'b1; dbg_wdata = 32'h8000_0008;
        @(negedge clk);
        cfg_core_we = 1'b0; dbg_we = 1'b0;
        #1;
        check("R2 debug wins same-cycle write", dbg_rdata, 32'h8000_0008);
        @(negedge clk);
    endtask

    task automatic t_slow_route();
        logic [31:0] rd; logic er; int c;
        core_access(32'h8000_0010, 1'b1, 4'hF, 32'hA5A5_0001, rd, er, c);
        check("R7 routed write latency", c, 3);
        check("R7 routed write no error", {31'd0, er}, 0);
        core_access(32'h8000_0010, 1'b0, 4'hF, 0, rd, er, c);
        check("R7 routed read latency", c, 3);
        check("R7 routed read data", rd, 32'hA5A5_0001);
    endtask

    task automatic t_fast_bytes();
        logic [31:0] rd; logic er; int c;
        core_cfg(32'h8000_0009);
        @(negedge clk);
        core_access(32'h8000_0010, 1'b0, 4'hF, 0, rd, er, c);
        check("R6 fast read latency", c, 1);
        check("R6 fast read data", rd, 32'hA5A5_0001);
        core_access(32'h8000_0020, 1'b1, 4'hF, 32'hAABB_CCDD, rd, er, c);
        check("R6 fast write latency", c, 1);
        core_access(32'h8000_0020, 1'b1, 4'b0011, 32'h1234_5678, rd, er, c);
        core_access(32'h8000_0020, 1'b0, 4'hF, 0, rd, er, c);
        check("R9 low-half byte enables", rd, 32'hAABB_5678);
        core_access(32'h8000_0020, 1'b1, 4'b1000, 32'h9900_0000, rd, er, c);
        core_access(32'h8000_0020, 1'b0, 4'hF, 0, rd, er, c);
        check("R9 top byte enable", rd, 32'h99BB_5678);
    endtask

    task automatic t_alias();
        logic [31:0] rd; logic er; int c;
        core_access(32'h8000_0040, 1'b1, 4'hF, 32'h0B0B_0B0B, rd, er, c);
        core_access(32'h8000_1040, 1'b0, 4'hF, 0, rd, er, c);
        check("R5 alias one array size up", rd, 32'h0B0B_0B0B);
        core_access(32'h8FFF_F040, 1'b0, 4'hF, 0, rd, er, c);
        check("R5 alias window top", rd, 32'h0B0B_0B0B);
    endtask

    task automatic t_miss();
        logic [31:0] rd; logic er; int c; int seen = 0;
        core_req = 1'b1; core_addr = 32'h9000_0040; core_we = 1'b1;
        core_be = 4'hF; core_wdata = 32'hDEAD_BEEF;
        for (int i = 0; i < 5; i++) begin
            #1;
            if (core_ready) seen++;
            @(negedge clk);
        end
        core_req = 1'b0;
        check("R4 no ready outside window", seen, 0);
        core_access(32'h8000_0040, 1'b0, 4'hF, 0, rd, er, c);
        check("R4 array unchanged by miss", rd, 32'h0B0B_0B0B);
    endtask

    task automatic t_bd_port();
        logic [31:0] rd; logic er; int c;
        bd_access(32'h0000_0080, 1'b1, 4'hF, 32'hD00D_0001, rd, er, c);
        check("R8 side-door write latency", c, 3);
        check("R8 side-door write no error", {31'd0, er}, 0);
        core_access(32'h8000_0080, 1'b0, 4'hF, 0, rd, er, c);
        check("R8 side-door write seen by core", rd, 32'hD00D_0001);
        bd_access(32'h1234_5080, 1'b0, 4'hF, 0, rd, er, c);
        check("R8 side-door read latency", c, 3);
        check("R8 side-door read data", rd, 32'hD00D_0001);
    endtask

    task automatic t_wprot();
        logic [31:0] rd; logic er; int c;
        dbg_write(32'h8000_000D);
        @(negedge clk);
        bd_access(32'h0000_0080, 1'b1, 4'hF, 32'hEEEE_EEEE, rd, er, c);
        check("R10 protected write completes", c, 3);
        check("R10 protected write error", {31'd0, er}, 1);
        bd_access(32'h0000_0080, 1'b0, 4'hF, 0, rd, er, c);
        check("R10 protected write dropped", rd, 32'hD00D_0001);
        check("R10 read not flagged", {31'd0, er}, 0);
    endtask

    task automatic t_disabled();
        logic [31:0] rd; logic er; int c;
        dbg_write(32'h8000_0000);
        @(negedge clk);
        core_access(32'h8000_0080, 1'b1, 4'hF, 32'hFFFF_0000, rd, er, c);
        check("R11 error response latency", c, 1);
        check("R11 error response flag", {31'd0, er}, 1);
        dbg_write(32'h8000_0001);
        @(negedge clk);
        bd_access(32'h0000_0080, 1'b1, 4'hF, 32'h1111_1111, rd, er, c);
        check("R12 disabled side-door write error", {31'd0, er}, 1);
        bd_access(32'h0000_0080, 1'b0, 4'hF, 0, rd, er, c);
        check("R12 disabled side-door read data zero", rd, 0);
        check("R12 disabled side-door read latency", c, 3);
        core_access(32'h8000_0080, 1'b0, 4'hF, 0, rd, er, c);
        check("R11 R12 array unchanged", rd, 32'hD00D_0001);
    endtask

    task automatic t_priority();
        logic [31:0] crd, brd; logic cer, ber; int cc, bc;
        dbg_write(32'h8000_000B);
        @(negedge clk);
        fork
            core_access(32'h8000_0040, 1'b0, 4'hF, 0, crd, cer, cc);
            bd_access(32'h0000_0080, 1'b0, 4'hF, 0, brd, ber, bc);
        join
        check("R13 core first: core latency", cc, 1);
        check("R13 core first: side-door latency", bc, 4);
        check("R13 core first: core data", crd, 32'h0B0B_0B0B);
        check("R13 core first: side-door data", brd, 32'hD00D_0001);
        dbg_write(32'h8000_0009);
        @(negedge clk);
        fork
            core_access(32'h8000_0040, 1'b0, 4'hF, 0, crd, cer, cc);
            bd_access(32'h0000_0080, 1'b0, 4'hF, 0, brd, ber, bc);
        join
        check("R13 side-door first: side-door latency", bc, 3);
        check("R13 side-door first: core latency", cc, 4);
        check("R13 side-door first: core data", crd, 32'h0B0B_0B0B);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        cfg_core_we = 1'b0; cfg_core_wdata = '0;
        dbg_we = 1'b0; dbg_wdata = '0;
        core_req = 1'b0; core_addr = '0; core_we = 1'b0; core_be = '0; core_wdata = '0;
        bd_req = 1'b0; bd_addr = '0; bd_we = 1'b0; bd_be = '0; bd_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_reserved();
        t_cfg_ports();
        t_slow_route();
        t_fast_bytes();
        t_alias();
        t_miss();
        t_bd_port();
        t_wprot();
        t_disabled();
        t_priority();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule